// File: doc/BRIEF.md
# ADC Sample Calibration Corrector

This block sits in the sampling-clock domain behind the ADC deserialiser. It corrects every raw 16-bit two's-complement sample in three steps. First it adds a signed offset. Then it scales the result by an unsigned fixed-point gain whose most significant bit weighs one. Finally it rounds the scaled value and clamps it symmetrically to a programmable 15-bit magnitude limit. The corrected stream leaves the block with a fixed three-cycle latency, and its valid flag is delayed to match.

Gain, offset and limit arrive on configuration inputs that may change at any time. The datapath sees them only when a one-cycle apply strobe copies all three into an active set at once. Each active set travels down the pipeline with the sample it was sampled against, so no sample is ever corrected with a gain from one set and an offset from another.

Top module: `adc_cal_corrector`

## Requirements
- R1: After a synchronous reset the output valid flag and the output sample are 0. Until the first apply, samples are corrected with gain 0x8000 (unity), offset 0 and limit 0x7FFF.
- R2: The gain is a 16-bit unsigned value. Bit 15 weighs 1.0 and bit 0 weighs 2^-15, so 0x8000 passes samples unchanged and 0xFFFF scales by just under two.
- R3: The offset is a 16-bit two's-complement value. It is added to the two's-complement sample before the gain is applied, and the sum is kept at 17 bits so that it never wraps.
- R4: The scaled value is the product divided by 2^15 with rounding half toward positive infinity (floor(p/2^15 + 1/2)).
- R5: The rounded value is clamped to the range from -L to +L, where L is the 15-bit unsigned limit. A limit of 0 forces every output to 0, and with L = 0x7FFF the input -32768 leaves as -32767.
- R6: When cal_apply is high at a clock edge, gain, offset and limit are all loaded from the configuration inputs at that edge. Changes on the configuration inputs while cal_apply is low do not affect any output.
- R7: Every sample is corrected with the one set that was active at the edge where the sample was accepted, even when an apply occurs while earlier samples are still in the pipeline.
- R8: out_valid equals in_valid from three clock edges earlier, at full throughput with no bubbles, and out_sample carries the corrected value of that sample whenever out_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Raw sample present this cycle |
| in_sample | input | 16 | Raw sample, two's complement |
| cfg_gain | input | 16 | Gain candidate, unsigned, 1 integer and 15 fraction bits |
| cfg_offset | input | 16 | Offset candidate, two's complement |
| cfg_limit | input | 15 | Clamp magnitude candidate, unsigned |
| cal_apply | input | 1 | Loads all three candidates into the active set |
| out_valid | output | 1 | Corrected sample present this cycle |
| out_sample | output | 16 | Corrected sample, two's complement |

## Verification
A sample presented before clock edge e appears at the outputs after edge e+2, three registered edges in all. An apply at edge e affects only samples accepted from edge e+1 onward. The bench drives inputs and samples outputs on the falling edge. It keeps a three-deep queue of expected results, each computed from a model of the active set taken when the sample was driven, and compares the oldest entry before every new drive. The sweeps cover sample ranges across a set of gains, offsets and limits, plus applies in the middle of a stream and gaps in the valid flag, so every result is checked exactly in the cycle it is due.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 15;
    localparam int LIM_W     = 15;
    localparam int LATENCY   = 3;

    // sample + offset, one extra bit so the sum cannot wrap
    localparam int SUM_W  = SAMPLE_W + 1;
    // signed sum times zero-extended gain
    localparam int PROD_W = SUM_W + GAIN_W + 1;

    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << GAIN_FRAC;
    localparam logic [LIM_W-1:0]  LIM_RESET  = '1;
    localparam logic [PROD_W-1:0] ROUND_HALF = PROD_W'(1) << (GAIN_FRAC - 1);

    typedef struct packed {
        logic [GAIN_W-1:0]   gain;
        logic [SAMPLE_W-1:0] offset;
        logic [LIM_W-1:0]    limit;
    } cal_set_t;

    typedef struct packed {
        logic              valid;
        logic [SUM_W-1:0]  sum;
        logic [GAIN_W-1:0] gain;
        logic [LIM_W-1:0]  limit;
    } st1_t;

    typedef struct packed {
        logic              valid;
        logic [PROD_W-1:0] prod;
        logic [LIM_W-1:0]  limit;
    } st2_t;

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] data;
    } st3_t;

endpackage

// File: rtl/cal_shadow.sv
module cal_shadow
    import adc_cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     apply,
    input  cal_set_t cand,
    output cal_set_t active
);

    cal_set_t set_d, set_q;

    always_comb begin
        set_d = set_q;
        if (apply) begin
            set_d = cand;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '{gain: GAIN_UNITY, offset: '0, limit: LIM_RESET};
        end else begin
            set_q <= set_d;
        end
    end

    assign active = set_q;

    // R1: active set holds the documented defaults when reset is released
    a_r1_reset_set: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (set_q.gain == GAIN_UNITY && set_q.offset == '0 && set_q.limit == LIM_RESET));

    // R6: an apply loads all three candidates together
    a_r6_apply_loads: assert property (@(posedge clk) disable iff (rst)
        apply |=> (set_q == $past(cand)));

    // R6: without an apply the active set is frozen
    a_r6_hold_no_apply: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(set_q));

endmodule

// File: rtl/corr_scale.sv
module corr_scale
    import adc_cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  cal_set_t            cal,
    output st2_t                st2
);

    typedef struct packed {
        st1_t s1;
        st2_t s2;
    } scale_pipe_t;

    scale_pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;

        // stage 1: widen and add offset; gain and limit ride along (R7)
        pipe_d.s1.valid = in_valid;
        pipe_d.s1.sum   = SUM_W'($signed(in_sample)) + SUM_W'($signed(cal.offset));
        pipe_d.s1.gain  = cal.gain;
        pipe_d.s1.limit = cal.limit;

        // stage 2: signed sum times unsigned gain
        pipe_d.s2.valid = pipe_q.s1.valid;
        pipe_d.s2.prod  = PROD_W'($signed(pipe_q.s1.sum))
                        * PROD_W'($signed({1'b0, pipe_q.s1.gain}));
        pipe_d.s2.limit = pipe_q.s1.limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign st2 = pipe_q.s2;

    // R7: the gain travelling with a sample is the one active when it entered
    a_r7_gain_tracks_sample: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (pipe_q.s1.gain == $past(cal.gain)));

    // R7: the limit travelling with a sample is the one active when it entered
    a_r7_limit_tracks_sample: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (pipe_q.s1.limit == $past(cal.limit)));

endmodule

// File: rtl/corr_clamp.sv
module corr_clamp
    import adc_cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  st2_t                st2,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);

    st3_t s3_d, s3_q;

    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] shifted;
    logic signed [PROD_W-1:0] lim_hi;
    logic signed [PROD_W-1:0] lim_lo;
    logic signed [PROD_W-1:0] clipped;

    always_comb begin
        // round half up, then drop the fraction bits (R4)
        biased  = $signed(st2.prod + ROUND_HALF);
        shifted = biased >>> GAIN_FRAC;

        // symmetric clamp (R5)
        lim_hi = $signed(PROD_W'(st2.limit));
        lim_lo = -lim_hi;
        if (shifted > lim_hi) begin
            clipped = lim_hi;
        end else if (shifted < lim_lo) begin
            clipped = lim_lo;
        end else begin
            clipped = shifted;
        end

        s3_d.valid = st2.valid;
        s3_d.data  = SAMPLE_W'(clipped);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_q <= '0;
        end else begin
            s3_q <= s3_d;
        end
    end

    assign out_valid  = s3_q.valid;
    assign out_sample = s3_q.data;

    // R5: every valid output lies inside the limit carried with it
    a_r5_within_limit: assert property (@(posedge clk) disable iff (rst)
        s3_q.valid |->
            (($signed(s3_q.data) <= $signed({1'b0, $past(st2.limit)})) &&
             ($signed(s3_q.data) >= -$signed({1'b0, $past(st2.limit)}))));

endmodule

// File: rtl/adc_cal_corrector.sv
module adc_cal_corrector
    import adc_cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [GAIN_W-1:0]   cfg_gain,
    input  logic [SAMPLE_W-1:0] cfg_offset,
    input  logic [LIM_W-1:0]    cfg_limit,
    input  logic                cal_apply,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);

    cal_set_t cand_set;
    cal_set_t active_set;
    st2_t     scaled;

    assign cand_set = '{gain: cfg_gain, offset: cfg_offset, limit: cfg_limit};

    cal_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .apply  (cal_apply),
        .cand   (cand_set),
        .active (active_set)
    );

    corr_scale u_scale (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .cal       (active_set),
        .st2       (scaled)
    );

    corr_clamp u_clamp (
        .clk        (clk),
        .rst        (rst),
        .st2        (scaled),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    // edges since reset release, saturating at the pipeline depth
    logic [1:0] settle_d, settle_q;

    always_comb begin
        settle_d = settle_q;
        if (settle_q != 2'(LATENCY)) begin
            settle_d = settle_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_q <= '0;
        end else begin
            settle_q <= settle_d;
        end
    end

    // R8: valid emerges exactly three edges after it enters
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (settle_q == 2'(LATENCY)) |-> (out_valid == $past(in_valid, 3)));

    // R1: outputs are quiet on the first edge after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_sample == '0));

endmodule

// File: tb/tb_adc_cal_corrector.sv
`timescale 1ns/1ps
module tb_adc_cal_corrector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [15:0] cfg_gain = '0;
    logic [15:0] cfg_offset = '0;
    logic [14:0] cfg_limit = '0;
    logic        cal_apply = 1'b0;
    wire         out_valid;
    wire  [15:0] out_sample;

    adc_cal_corrector dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .cfg_gain   (cfg_gain),
        .cfg_offset (cfg_offset),
        .cfg_limit  (cfg_limit),
        .cal_apply  (cal_apply),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench model of the active calibration set
    int m_gain = 32768;
    int m_off = 0;
    int m_lim = 32767;

    // candidate values driven on the configuration inputs
    int c_gain = 0;
    int c_off = 0;
    int c_lim = 0;

    // expected results, slot 2 is due now
    bit    ev [3];
    int    ed [3];
    string et [3];

    int lcg = 24680;

    function automatic int sx16(int x);
        int y;
        y = x & 32'hFFFF;
        if (y >= 32768) y = y - 65536;
        return y;
    endfunction

    function automatic int next16();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 8) & 32'hFFFF;
    endfunction

    function automatic int model(int s, int g, int o, int l);
        longint sum;
        longint p;
        longint r;
        sum = longint'(s) + longint'(o);
        p = sum * longint'(g);
        r = (p + 64'sd16384) >>> 15;
        if (r > l) r = l;
        if (r < -l) r = -l;
        return int'(r);
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== ev[2]) begin
            fails++;
            $display("FAIL R8 (%s): out_valid=%0b expected %0b", et[2], out_valid, ev[2]);
        end
        if (ev[2]) begin
            checks++;
            if (int'($signed(out_sample)) != ed[2]) begin
                fails++;
                $display("FAIL %s: out_sample=%0d expected %0d", et[2],
                         int'($signed(out_sample)), ed[2]);
            end
        end
    endtask

    task automatic step(input bit v, input int s, input bit ap, input string tag);
        check_out();
        ev[2] = ev[1]; ed[2] = ed[1]; et[2] = et[1];
        ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0];
        ev[0] = v;
        ed[0] = model(sx16(s), m_gain, m_off, m_lim);
        et[0] = tag;
        in_valid   = v;
        in_sample  = 16'(s);
        cal_apply  = ap;
        cfg_gain   = 16'(c_gain);
        cfg_offset = 16'(c_off);
        cfg_limit  = 15'(c_lim);
        if (ap) begin
            m_gain = c_gain & 32'hFFFF;
            m_off  = sx16(c_off);
            m_lim  = c_lim & 32'h7FFF;
        end
        @(negedge clk);
    endtask

    task automatic apply_set(input int g, input int o, input int l, input string tag);
        c_gain = g; c_off = o; c_lim = l;
        step(1'b0, 0, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8: watchdog expired, run incomplete (actual hung, expected done)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            ev[i] = 1'b0; ed[i] = 0; et[i] = "R1";
        end
        repeat (4) @(negedge clk);
        // R1: outputs idle while reset is held
        checks++;
        if (out_valid !== 1'b0 || out_sample !== 16'h0000) begin
            fails++;
            $display("FAIL R1: valid=%0b data=%h expected 0 and 0000", out_valid, out_sample);
        end
        rst = 1'b0;

        // R1: defaults until the first apply; -32768 hits the clamp (R5)
        for (int k = 0; k < 256; k++) begin
            int s;
            s = -32768 + k * 257;
            step(1'b1, s, 1'b0, (s == -32768) ? "R5" : "R1");
        end
        step(1'b1, 32767, 1'b0, "R1");

        // R6: candidates change but no apply
        c_gain = 16'h4000; c_off = 100; c_lim = 5;
        for (int k = 0; k < 64; k++) step(1'b1, next16(), 1'b0, "R6");

        // R2: gain sweep
        begin
            int gains [6] = '{0, 1, 16'h4000, 16'h8000, 16'hC000, 16'hFFFF};
            for (int gi = 0; gi < 6; gi++) begin
                apply_set(gains[gi], 0, 32767, "R2");
                for (int k = 0; k < 64; k++) step(1'b1, k * 1021 - 32768, 1'b0, "R2");
            end
        end

        // R3: offset sweep, extremes show the sum does not wrap
        begin
            int offs [4] = '{16'h7FFF, 16'h8000, 16'h1234, 16'hFF00};
            int gs   [2] = '{16'h8000, 16'h4000};
            for (int oi = 0; oi < 4; oi++) begin
                for (int gi = 0; gi < 2; gi++) begin
                    apply_set(gs[gi], offs[oi], 32767, "R3");
                    step(1'b1, 32767, 1'b0, "R3");
                    step(1'b1, -32768, 1'b0, "R3");
                    for (int k = 0; k < 62; k++) step(1'b1, next16(), 1'b0, "R3");
                end
            end
        end

        // R4: halves round toward positive infinity
        begin
            int rg [3] = '{16'h4000, 16'h2000, 16'h0001};
            for (int gi = 0; gi < 3; gi++) begin
                apply_set(rg[gi], 0, 32767, "R4");
                for (int s = -6; s <= 6; s++) step(1'b1, s, 1'b0, "R4");
                step(1'b1, 16384, 1'b0, "R4");
                step(1'b1, -16384, 1'b0, "R4");
                step(1'b1, 32767, 1'b0, "R4");
            end
        end

        // R5: limit sweep including zero
        begin
            int lims [4] = '{0, 1, 100, 16'h4000};
            for (int li = 0; li < 4; li++) begin
                apply_set(16'hFFFF, 16'h0100, lims[li], "R5");
                for (int k = 0; k < 64; k++) step(1'b1, next16(), 1'b0, "R5");
            end
        end

        // R7: applies in the middle of a full-rate stream
        for (int k = 0; k < 200; k++) begin
            bit ap;
            ap = (k % 7) == 3;
            if (ap) begin
                c_gain = next16(); c_off = next16(); c_lim = next16() & 32'h7FFF;
            end
            step(1'b1, next16(), ap, "R7");
        end

        // R8: gaps in the valid flag
        apply_set(16'h9000, 16'hFFF0, 30000, "R8");
        for (int k = 0; k < 150; k++) step((k % 3) != 1, next16(), 1'b0, "R8");
        for (int k = 0; k < 4; k++) step(1'b0, 0, 1'b0, "R8");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule